// File: doc/BRIEF.md
# Acquisition and Lock-Detect Supervisor

This block supervises a tracking loop as it acquires and holds lock. A four-state controller steps through search, verify, lock and false-lock. In search and verify, two counters race each other. A phase-error accumulator counts samples whose error was judged within tolerance. An integration counter counts every sample. The first of the two to reach its programmed limit decides where the machine goes next, and then both clear so that a new race begins. Lock is declared only after a programmable number of accumulator wins in verify.

In lock, a second race runs. A false-lock accumulator counts samples on which the false-lock indicator was set, and a lock counter counts every sample. If the false-lock accumulator wins, the machine moves to false-lock. It dwells there for a programmed number of samples and then restarts acquisition from search. The phase-error test and the false-lock test are made upstream and arrive as per-sample strobes. The block reports its state code, a lock flag and every counter.

Top module: `lkd_acq_supervisor`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state becomes search and every counter output becomes zero.
- R2: The state code is search=2'b00, verify=2'b01, lock=2'b10, false-lock=2'b11. `locked_o` is high exactly while the state code is 2'b10.
- R3: In search, on each valid sample the accumulator adds `err_ok` and the integration counter adds 1. If the accumulator reaches `acc_thresh` first, the state becomes verify. If the integration counter reaches `int_len` first, the state stays search. Either result clears both counters.
- R4: When the accumulator and the integration counter reach their limits on the same sample, the accumulator win takes effect.
- R5: In verify, an integration-counter win returns the state to search. Whenever the state enters search, the verify count is cleared.
- R6: In verify, an accumulator win adds 1 to the verify count. The state becomes lock when the new count reaches `verify_need`, where a value of 0 acts as 1. Otherwise the state stays verify.
- R7: In lock, the false-lock accumulator adds `fl_ind` and the lock counter adds 1 on each valid sample. If the accumulator reaches `fl_thresh` first, or on the same sample as the counter, the state becomes false-lock. If the lock counter reaches `lock_len` first, the state stays lock. Either result clears both.
- R8: In false-lock, the hold counter counts valid samples. The state returns to search on the sample that brings it to `hold_len`, and the hold counter clears.
- R9: A cycle with `smp_vld` low changes no state and no counter, whatever `err_ok` and `fl_ind` are.
- R10: The phase race counters are zero outside search and verify. The false-lock race counters are zero outside lock. The hold counter is zero outside false-lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | One loop sample is presented this cycle |
| err_ok | input | 1 | Sample phase error is within tolerance |
| fl_ind | input | 1 | Sample shows the false-lock signature |
| acc_thresh | input | ACC_W (8) | Phase-error accumulator limit |
| int_len | input | CNT_W (10) | Integration period in samples |
| verify_need | input | VER_W (4) | Verify wins needed for lock (0 acts as 1) |
| fl_thresh | input | ACC_W (8) | False-lock accumulator limit |
| lock_len | input | CNT_W (10) | Lock observation period in samples |
| hold_len | input | CNT_W (10) | False-lock dwell in samples |
| state_o | output | 2 | State code |
| locked_o | output | 1 | High in lock |
| pe_acc_o | output | ACC_W (8) | Phase-error accumulator |
| int_cnt_o | output | CNT_W (10) | Integration counter |
| verify_cnt_o | output | VER_W (4) | Verify win count |
| fl_acc_o | output | ACC_W (8) | False-lock accumulator |
| lock_cnt_o | output | CNT_W (10) | Lock counter |
| hold_cnt_o | output | CNT_W (10) | False-lock hold counter |

## Verification
The hardest situation to reach is the false-lock path. To get there, the machine must first win in search, then win several races in verify, and then lose the race in lock, all with the right pattern of strobes. The bench uses short thresholds and directed strobe sequences to walk through the whole cycle, including a tie on the same sample. It then changes the thresholds every few hundred cycles while the strobes are random, so that every state is entered many times. A behavioural model is compared with the design on every cycle.

// File: rtl/lkd_pkg.sv
`timescale 1ns/1ps
package lkd_pkg;

    typedef enum logic [1:0] {
        ST_SEARCH = 2'b00,
        ST_VERIFY = 2'b01,
        ST_LOCK   = 2'b10,
        ST_FALSE  = 2'b11
    } acq_state_e;

    // Outcome of one race on the current sample
    typedef struct packed {
        logic acc_win;
        logic cnt_win;
    } race_ev_t;

    function automatic logic is_acq_state(acq_state_e s);
        return (s == ST_SEARCH) || (s == ST_VERIFY);
    endfunction

    // Next-state decision from the race outcomes of this sample
    function automatic acq_state_e next_state(
        acq_state_e cur,
        race_ev_t   ph,
        race_ev_t   fl,
        logic       ver_done,
        logic       hold_done
    );
        acq_state_e nx;
        nx = cur;
        case (cur)
            ST_SEARCH: begin
                if (ph.acc_win)      nx = ST_VERIFY;
                else if (ph.cnt_win) nx = ST_SEARCH;
            end
            ST_VERIFY: begin
                if (ph.acc_win)      nx = ver_done ? ST_LOCK : ST_VERIFY;
                else if (ph.cnt_win) nx = ST_SEARCH;
            end
            ST_LOCK: begin
                if (fl.acc_win)      nx = ST_FALSE;
                else if (fl.cnt_win) nx = ST_LOCK;
            end
            ST_FALSE: begin
                if (hold_done)       nx = ST_SEARCH;
            end
            default:                 nx = ST_SEARCH;
        endcase
        return nx;
    endfunction

endpackage

// File: rtl/lkd_race.sv
`timescale 1ns/1ps
module lkd_race
    import lkd_pkg::*;
#(
    parameter int ACC_W = 8,
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    input  logic             hit,
    input  logic [ACC_W-1:0] thresh,
    input  logic [CNT_W-1:0] len,
    output logic [ACC_W-1:0] acc_o,
    output logic [CNT_W-1:0] cnt_o,
    output race_ev_t         ev_o
);
    localparam int AW1 = ACC_W + 1;
    localparam int CW1 = CNT_W + 1;

    logic [ACC_W-1:0] acc_q;
    logic [CNT_W-1:0] cnt_q;
    logic [AW1-1:0]   acc_nx;
    logic [CW1-1:0]   cnt_nx;
    race_ev_t         ev;

    always_comb begin
        acc_nx     = {1'b0, acc_q} + {{ACC_W{1'b0}}, hit};
        cnt_nx     = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
        ev.acc_win = step && (acc_nx >= {1'b0, thresh});
        ev.cnt_win = step && !ev.acc_win && (cnt_nx >= {1'b0, len});
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (step) begin
            if (ev.acc_win || ev.cnt_win) begin
                acc_q <= '0;
                cnt_q <= '0;
            end else begin
                acc_q <= acc_nx[ACC_W-1:0];
                cnt_q <= cnt_nx[CNT_W-1:0];
            end
        end
    end

    assign acc_o = acc_q;
    assign cnt_o = cnt_q;
    assign ev_o  = ev;

    AST_ACC_NOT_AHEAD: assert property (@(posedge clk) disable iff (rst)
        {{(CNT_W > ACC_W ? CNT_W - ACC_W : 0){1'b0}}, acc_q} <= cnt_q); // R3

    AST_WIN_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (ev.acc_win || ev.cnt_win) |=> (acc_q == '0 && cnt_q == '0)); // R3

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!step && !clear) |=> ($stable(acc_q) && $stable(cnt_q))); // R9

endmodule

// File: rtl/lkd_verify_ctr.sv
`timescale 1ns/1ps
module lkd_verify_ctr #(
    parameter int VER_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    input  logic [VER_W-1:0] need,
    output logic [VER_W-1:0] cnt_o,
    output logic             done_o
);
    localparam int VW1 = VER_W + 1;

    logic [VER_W-1:0] cnt_q;
    logic [VER_W-1:0] need_eff;
    logic [VW1-1:0]   cnt_nx;

    always_comb begin
        need_eff = (need == '0) ? {{(VER_W-1){1'b0}}, 1'b1} : need;
        cnt_nx   = {1'b0, cnt_q} + {{VER_W{1'b0}}, 1'b1};
        done_o   = inc && (cnt_nx >= {1'b0, need_eff});
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (inc && !cnt_nx[VER_W]) begin
            cnt_q <= cnt_nx[VER_W-1:0];
        end
    end

    assign cnt_o = cnt_q;

    AST_VCNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr && cnt_q != '1) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R6

    AST_VCNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0)); // R5

endmodule

// File: rtl/lkd_hold_ctr.sv
`timescale 1ns/1ps
module lkd_hold_ctr #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             step,
    input  logic [CNT_W-1:0] len,
    output logic [CNT_W-1:0] cnt_o,
    output logic             done_o
);
    localparam int CW1 = CNT_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CW1-1:0]   cnt_nx;

    always_comb begin
        cnt_nx = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
        done_o = step && (cnt_nx >= {1'b0, len});
    end

    always_ff @(posedge clk) begin
        if (rst || clr || done_o) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_nx[CNT_W-1:0];
        end
    end

    assign cnt_o = cnt_q;

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!step && !clr) |=> $stable(cnt_q)); // R9

    AST_HOLD_DONE_CLR: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (cnt_q == '0)); // R8

endmodule

// File: rtl/lkd_acq_supervisor.sv
`timescale 1ns/1ps
module lkd_acq_supervisor
    import lkd_pkg::*;
#(
    parameter int ACC_W = 8,
    parameter int CNT_W = 10,
    parameter int VER_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_vld,
    input  logic             err_ok,
    input  logic             fl_ind,
    input  logic [ACC_W-1:0] acc_thresh,
    input  logic [CNT_W-1:0] int_len,
    input  logic [VER_W-1:0] verify_need,
    input  logic [ACC_W-1:0] fl_thresh,
    input  logic [CNT_W-1:0] lock_len,
    input  logic [CNT_W-1:0] hold_len,
    output logic [1:0]       state_o,
    output logic             locked_o,
    output logic [ACC_W-1:0] pe_acc_o,
    output logic [CNT_W-1:0] int_cnt_o,
    output logic [VER_W-1:0] verify_cnt_o,
    output logic [ACC_W-1:0] fl_acc_o,
    output logic [CNT_W-1:0] lock_cnt_o,
    output logic [CNT_W-1:0] hold_cnt_o
);
    acq_state_e state_q;
    acq_state_e state_d;

    logic     ph_step, fl_step, hold_step;
    logic     ph_clr, fl_clr, hold_clr;
    race_ev_t ph_ev, fl_ev;
    logic     ver_inc, ver_clr, ver_done;
    logic     hold_done;

    always_comb begin
        ph_step   = smp_vld && is_acq_state(state_q);
        fl_step   = smp_vld && (state_q == ST_LOCK);
        hold_step = smp_vld && (state_q == ST_FALSE);
        ph_clr    = !is_acq_state(state_q);
        fl_clr    = (state_q != ST_LOCK);
        hold_clr  = (state_q != ST_FALSE);
    end

    // Phase-error race, active during acquisition
    lkd_race #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_ph_race (
        .clk    (clk),
        .rst    (rst),
        .clear  (ph_clr),
        .step   (ph_step),
        .hit    (err_ok && ph_step),
        .thresh (acc_thresh),
        .len    (int_len),
        .acc_o  (pe_acc_o),
        .cnt_o  (int_cnt_o),
        .ev_o   (ph_ev)
    );

    // False-lock race, active while locked
    lkd_race #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_fl_race (
        .clk    (clk),
        .rst    (rst),
        .clear  (fl_clr),
        .step   (fl_step),
        .hit    (fl_ind && fl_step),
        .thresh (fl_thresh),
        .len    (lock_len),
        .acc_o  (fl_acc_o),
        .cnt_o  (lock_cnt_o),
        .ev_o   (fl_ev)
    );

    always_comb begin
        ver_inc = ph_ev.acc_win && (state_q == ST_VERIFY);
        state_d = next_state(state_q, ph_ev, fl_ev, ver_done, hold_done);
        ver_clr = (state_d == ST_SEARCH) && (state_q != ST_SEARCH);
    end

    lkd_verify_ctr #(.VER_W(VER_W)) u_verify (
        .clk    (clk),
        .rst    (rst),
        .clr    (ver_clr),
        .inc    (ver_inc),
        .need   (verify_need),
        .cnt_o  (verify_cnt_o),
        .done_o (ver_done)
    );

    lkd_hold_ctr #(.CNT_W(CNT_W)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .clr    (hold_clr),
        .step   (hold_step),
        .len    (hold_len),
        .cnt_o  (hold_cnt_o),
        .done_o (hold_done)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_SEARCH;
        else     state_q <= state_d;
    end

    assign state_o  = state_q;
    assign locked_o = (state_q == ST_LOCK);

    AST_SEARCH_EXITS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SEARCH) |=> (state_q == ST_SEARCH || state_q == ST_VERIFY)); // R3

    AST_VERIFY_EXITS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_VERIFY) |=> (state_q != ST_FALSE)); // R6

    AST_LOCK_EXITS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOCK) |=> (state_q == ST_LOCK || state_q == ST_FALSE)); // R7

    AST_FALSE_EXITS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FALSE) |=> (state_q == ST_FALSE || state_q == ST_SEARCH)); // R8

    AST_NO_SAMPLE_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> $stable(state_q)); // R9

    AST_SEARCH_VCNT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SEARCH) |-> (verify_cnt_o == '0)); // R5

    AST_PH_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !is_acq_state(state_q) |-> (pe_acc_o == '0 && int_cnt_o == '0)); // R10

    AST_FL_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_LOCK) |-> (fl_acc_o == '0 && lock_cnt_o == '0)); // R10

    AST_HOLD_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_FALSE) |-> (hold_cnt_o == '0)); // R10

endmodule

// File: tb/lkd_acq_supervisor_tb_top.sv
`timescale 1ns/1ps
module lkd_acq_supervisor_tb_top;

    localparam int ACC_W = 8;
    localparam int CNT_W = 10;
    localparam int VER_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             smp_vld = 1'b0;
    logic             err_ok = 1'b0;
    logic             fl_ind = 1'b0;
    logic [ACC_W-1:0] acc_thresh = 8'd3;
    logic [CNT_W-1:0] int_len = 10'd6;
    logic [VER_W-1:0] verify_need = 4'd2;
    logic [ACC_W-1:0] fl_thresh = 8'd2;
    logic [CNT_W-1:0] lock_len = 10'd5;
    logic [CNT_W-1:0] hold_len = 10'd4;

    logic [1:0]       state_o;
    logic             locked_o;
    logic [ACC_W-1:0] pe_acc_o;
    logic [CNT_W-1:0] int_cnt_o;
    logic [VER_W-1:0] verify_cnt_o;
    logic [ACC_W-1:0] fl_acc_o;
    logic [CNT_W-1:0] lock_cnt_o;
    logic [CNT_W-1:0] hold_cnt_o;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    cmp_en   = 1'b0;
    bit    done     = 1'b0;
    string cur_req  = "R1";

    // Behavioural reference state
    int m_st, m_pa, m_ic, m_vc, m_fa, m_lc, m_hc;

    always #10 clk = ~clk; // 50 MHz

    lkd_acq_supervisor #(.ACC_W(ACC_W), .CNT_W(CNT_W), .VER_W(VER_W)) dut_i (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .err_ok(err_ok), .fl_ind(fl_ind),
        .acc_thresh(acc_thresh), .int_len(int_len), .verify_need(verify_need),
        .fl_thresh(fl_thresh), .lock_len(lock_len), .hold_len(hold_len),
        .state_o(state_o), .locked_o(locked_o), .pe_acc_o(pe_acc_o),
        .int_cnt_o(int_cnt_o), .verify_cnt_o(verify_cnt_o), .fl_acc_o(fl_acc_o),
        .lock_cnt_o(lock_cnt_o), .hold_cnt_o(hold_cnt_o)
    );

    always @(posedge clk) begin
        int a, c, need;
        if (rst) begin
            m_st = 0; m_pa = 0; m_ic = 0; m_vc = 0; m_fa = 0; m_lc = 0; m_hc = 0;
        end else if (smp_vld) begin
            if (m_st == 0 || m_st == 1) begin
                a = m_pa + (err_ok ? 1 : 0);
                c = m_ic + 1;
                if (a >= int'(acc_thresh)) begin
                    m_pa = 0; m_ic = 0;
                    if (m_st == 0) m_st = 1;
                    else begin
                        need = (verify_need == 0) ? 1 : int'(verify_need);
                        m_vc = m_vc + 1;
                        if (m_vc >= need) m_st = 2;
                    end
                end else if (c >= int'(int_len)) begin
                    m_pa = 0; m_ic = 0;
                    if (m_st == 1) begin m_st = 0; m_vc = 0; end
                end else begin
                    m_pa = a; m_ic = c;
                end
            end else if (m_st == 2) begin
                a = m_fa + (fl_ind ? 1 : 0);
                c = m_lc + 1;
                if (a >= int'(fl_thresh)) begin
                    m_fa = 0; m_lc = 0; m_st = 3;
                end else if (c >= int'(lock_len)) begin
                    m_fa = 0; m_lc = 0;
                end else begin
                    m_fa = a; m_lc = c;
                end
            end else begin
                c = m_hc + 1;
                if (c >= int'(hold_len)) begin
                    m_hc = 0; m_st = 0; m_vc = 0;
                end else m_hc = c;
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            chk(cur_req, "state", int'(state_o), m_st);
            chk("R2", "locked", int'(locked_o), (m_st == 2) ? 1 : 0);
            chk(cur_req, "pe_acc", int'(pe_acc_o), m_pa);
            chk(cur_req, "int_cnt", int'(int_cnt_o), m_ic);
            chk(cur_req, "verify_cnt", int'(verify_cnt_o), m_vc);
            chk(cur_req, "fl_acc", int'(fl_acc_o), m_fa);
            chk(cur_req, "lock_cnt", int'(lock_cnt_o), m_lc);
            chk(cur_req, "hold_cnt", int'(hold_cnt_o), m_hc);
        end
    end

    task automatic smp(input logic v, input logic h, input logic f);
        smp_vld = v; err_ok = h; fl_ind = f;
        @(negedge clk);
    endtask

    task automatic summary();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "reset state", int'(state_o), 0);
        chk("R1", "reset pe_acc", int'(pe_acc_o), 0);
        chk("R1", "reset int_cnt", int'(int_cnt_o), 0);
        chk("R1", "reset verify_cnt", int'(verify_cnt_o), 0);
        chk("R1", "reset hold_cnt", int'(hold_cnt_o), 0);
        chk("R2", "reset locked", int'(locked_o), 0);
        rst = 1'b0;
        cmp_en = 1'b1;

        // R3: integration wins in search, stays in search
        cur_req = "R3";
        for (int i = 0; i < 5; i++) smp(1'b1, 1'b0, 1'b0);
        chk("R3", "int_cnt before window end", int'(int_cnt_o), 5);
        smp(1'b1, 1'b0, 1'b0);
        chk("R3", "search after integration win", int'(state_o), 0);
        chk("R3", "int_cnt cleared", int'(int_cnt_o), 0);
        // R3: accumulator wins in search
        smp(1'b1, 1'b1, 1'b0); smp(1'b1, 1'b0, 1'b0); smp(1'b1, 1'b1, 1'b0);
        chk("R3", "pe_acc counting", int'(pe_acc_o), 2);
        smp(1'b1, 1'b1, 1'b0);
        chk("R3", "verify after accumulator win", int'(state_o), 1);

        // R5: integration wins in verify
        cur_req = "R5";
        for (int i = 0; i < 6; i++) smp(1'b1, 1'b0, 1'b0);
        chk("R5", "search after verify loss", int'(state_o), 0);
        chk("R5", "verify count cleared", int'(verify_cnt_o), 0);

        // R6: verify wins up to lock
        cur_req = "R6";
        for (int i = 0; i < 3; i++) smp(1'b1, 1'b1, 1'b0);
        chk("R6", "into verify", int'(state_o), 1);
        for (int i = 0; i < 3; i++) smp(1'b1, 1'b1, 1'b0);
        chk("R6", "stay verify after one win", int'(state_o), 1);
        chk("R6", "verify count one", int'(verify_cnt_o), 1);
        for (int i = 0; i < 3; i++) smp(1'b1, 1'b1, 1'b0);
        chk("R6", "lock after two wins", int'(state_o), 2);
        chk("R2", "locked flag in lock", int'(locked_o), 1);

        // R9: no-sample cycles ignored
        cur_req = "R9";
        for (int i = 0; i < 4; i++) smp(1'b0, 1'b1, 1'b1);
        chk("R9", "lock held without samples", int'(state_o), 2);
        chk("R9", "fl_acc untouched", int'(fl_acc_o), 0);

        // R7: lock counter wins, then false-lock accumulator wins
        cur_req = "R7";
        smp(1'b1, 1'b0, 1'b1);
        for (int i = 0; i < 4; i++) smp(1'b1, 1'b0, 1'b0);
        chk("R7", "lock kept after lock window", int'(state_o), 2);
        chk("R7", "fl_acc cleared", int'(fl_acc_o), 0);
        smp(1'b1, 1'b0, 1'b1); smp(1'b0, 1'b0, 1'b1); smp(1'b1, 1'b0, 1'b1);
        chk("R7", "false-lock entered", int'(state_o), 3);
        chk("R2", "locked low in false-lock", int'(locked_o), 0);

        // R8: dwell then search
        cur_req = "R8";
        for (int i = 0; i < 3; i++) smp(1'b1, 1'b1, 1'b1);
        chk("R8", "still false-lock", int'(state_o), 3);
        chk("R8", "hold count", int'(hold_cnt_o), 3);
        chk("R10", "phase race idle in false-lock", int'(pe_acc_o), 0);
        smp(1'b1, 1'b1, 1'b1);
        chk("R8", "search after dwell", int'(state_o), 0);
        chk("R5", "verify count cleared from false-lock", int'(verify_cnt_o), 0);

        // R4: tie on same sample
        cur_req = "R4";
        acc_thresh = 8'd3; int_len = 10'd3;
        for (int i = 0; i < 3; i++) smp(1'b1, 1'b1, 1'b0);
        chk("R4", "tie in search goes verify", int'(state_o), 1);
        verify_need = 4'd0;
        for (int i = 0; i < 3; i++) smp(1'b1, 1'b1, 1'b0);
        chk("R4", "tie in verify counts as win", int'(state_o), 2);
        chk("R6", "need of 0 acts as 1", int'(verify_cnt_o), 1);
        fl_thresh = 8'd2; lock_len = 10'd2;
        smp(1'b1, 1'b0, 1'b1); smp(1'b1, 1'b0, 1'b1);
        chk("R7", "tie in lock goes false-lock", int'(state_o), 3);
        hold_len = 10'd1;
        smp(1'b1, 1'b0, 1'b0);
        chk("R8", "hold of one sample", int'(state_o), 0);

        // R10: random run with changing thresholds
        cur_req = "R10";
        for (int blk = 0; blk < 40; blk++) begin
            acc_thresh  = 8'(1 + $urandom_range(0, 3));
            int_len     = 10'(2 + $urandom_range(0, 4));
            verify_need = 4'($urandom_range(0, 3));
            fl_thresh   = 8'(1 + $urandom_range(0, 2));
            lock_len    = 10'(2 + $urandom_range(0, 5));
            hold_len    = 10'($urandom_range(0, 3));
            for (int i = 0; i < 250; i++)
                smp(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 2) != 0),
                    1'($urandom_range(0, 2) == 0));
        end
        smp(1'b0, 1'b0, 1'b0);
        summary();
    end

endmodule